// File: doc/BRIEF.md
# Pulse-Width Capture Receiver

This block turns an incoming digital waveform into a list of runs. Every time the input settles at a new level, the receiver stores one 16-bit entry in a small internal memory. The entry holds the level of the run that has just ended and its length. Lengths are counted in ticks of a clock divided down by a programmable factor, so the same memory can capture both short and long pulse trains. A glitch filter can discard pulses shorter than a programmable number of clock cycles. When the line stays quiet for longer than a programmable idle limit, the receiver appends a terminator entry, stops and raises a done flag.

Software-side logic sets the divider, filter and idle limits, raises the receive enable, waits for the done flag and then walks the stored entries through a combinational read port. A separate control clears the write position so the memory can be reused. A write that finds the memory full is dropped and sets a sticky error flag.

Top module: `pwcap_rx`

## Requirements
- R1: Each accepted level change writes one entry: bit 15 holds the level of the run that just ended and bits 14:0 hold its length in ticks, counted from the accepted change that began it. Entries fill addresses 0, 1, 2, … in order, and `wr_count` gives the number stored.
- R2: One tick occurs every `div_factor` clock cycles, with a factor of 0 treated as 1. A run of N·`div_factor` cycles is therefore stored as a length of N.
- R3: While `div_rst` is high, no ticks occur and the divider restarts from zero, so the idle timeout cannot advance.
- R4: With `filt_en` high, a new input level is accepted only after it has held for `filt_thr` consecutive clock cycles. A shorter pulse is dropped and writes no entry. With `filt_en` low, every level change is accepted.
- R5: Once `idle_thr` ticks have passed since the last accepted change (or since enable), the next tick without a change writes a terminator entry {current level, length 0}. The receiver then raises `rx_done` and writes nothing more until `rx_en` is lowered.
- R6: While `rx_en` is low, no entry is written and `rx_done` is low. Raising `rx_en` starts a new capture with its counts cleared.
- R7: When a run's length reaches 32767 ticks, an entry with that length is written and counting continues within the same run. A later entry then holds the remainder.
- R8: When `wr_count` equals the memory depth (16), further writes are dropped, `wr_count` stays at the depth and `rx_err` is set and held.
- R9: A one-cycle pulse on `wptr_rst` returns `wr_count` to 0 and clears `rx_err`.
- R10: After reset, `wr_count`, `rx_done` and `rx_err` are 0 and every entry reads 0.
- R11: `rd_data` shows the stored entry at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_in | input | 1 | Waveform being measured |
| div_factor | input | 8 | Clock cycles per tick (0 treated as 1) |
| div_rst | input | 1 | Holds the tick divider at zero |
| filt_en | input | 1 | Enables the glitch filter |
| filt_thr | input | 8 | Cycles a new level must hold before it is accepted |
| idle_thr | input | 16 | Quiet ticks allowed before reception ends |
| rx_en | input | 1 | Receive enable |
| wptr_rst | input | 1 | Clears the write position and error flag |
| rd_addr | input | 4 | Entry address to read |
| rd_data | output | 16 | Entry at rd_addr: level in bit 15, length in bits 14:0 |
| wr_count | output | 5 | Number of entries written |
| rx_done | output | 1 | Idle timeout has ended reception |
| rx_err | output | 1 | A write found the memory full |

## Verification
A wrong run-length count or a missed edge shows up at the ports once `rx_done` rises. At that point the stored entries no longer match the driven run lengths, or `wr_count` is off by the missing or extra entries. A faulty filter count or divider phase changes the length field by at least one tick. A faulty idle counter moves the `rx_done` rise outside the window that the idle limit allows. A pointer or full-detection fault shows in `wr_count` and `rx_err` as soon as the seventeenth write is attempted.

// File: rtl/pwcap_pkg.sv
// Shared types and widths for the pulse-width capture receiver.
package pwcap_pkg;
    localparam int ENTRY_W = 16;
    localparam int LEN_W   = ENTRY_W - 1;

    typedef struct packed {
        logic             level;
        logic [LEN_W-1:0] len;
    } run_entry_t;

    typedef enum logic [1:0] {
        RX_OFF  = 2'd0,
        RX_RUN  = 2'd1,
        RX_STOP = 2'd2
    } rx_state_e;
endpackage

// File: rtl/pwcap_tick_div.sv
// Tick divider: raises tick for one cycle every max(factor,1) clocks.
// Assumes factor may change at any time; the counter wraps on >= so it never runs away.
module pwcap_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] factor,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_v;

    // Last count value of one tick period.
    always_comb begin
        last_v = (factor == '0) ? '0 : factor - DIV_W'(1);
        tick   = !restart && (cnt_q == last_v);
    end

    // Cycle counter, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (cnt_q >= last_v) cnt_q <= '0;
        else cnt_q <= cnt_q + DIV_W'(1);
    end

    // R3
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/pwcap_glitch_filter.sv
// Glitch filter: registers the raw input once, then accepts a new level only
// after it has been seen for thr consecutive cycles (immediately when disabled
// or thr <= 1). Assumes thr is not changed while a candidate level is pending.
module pwcap_glitch_filter #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    output logic             lvl
);
    logic             sync_q;
    logic             lvl_q;
    logic [THR_W-1:0] hold_q;
    logic             accept;

    // Input register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sig_in;
    end

    // Accept when the candidate has held for thr cycles including this one.
    always_comb begin
        accept = !en || ({1'b0, hold_q} + (THR_W+1)'(1) >= {1'b0, thr});
    end

    // Accepted level and consecutive-mismatch counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            hold_q <= '0;
        end else if (sync_q == lvl_q) begin
            hold_q <= '0;
        end else if (accept) begin
            lvl_q  <= sync_q;
            hold_q <= '0;
        end else begin
            hold_q <= hold_q + THR_W'(1);
        end
    end

    assign lvl = lvl_q;

    // R4
    filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && thr >= THR_W'(2) && !$stable(lvl_q)) |-> ($past(sync_q, 2) == lvl_q));
endmodule

// File: rtl/pwcap_run_timer.sv
// Run timer: measures each run of the filtered level in ticks, requests an
// entry write on every accepted change, on length saturation and on idle
// timeout (terminator with length 0), then stops until rx_en is dropped.
// Assumes at most one write request per cycle is accepted downstream.
module pwcap_run_timer
    import pwcap_pkg::*;
#(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lvl,
    input  logic              rx_en,
    input  logic [IDLE_W-1:0] idle_thr,
    output logic              wr_req,
    output run_entry_t        wr_entry,
    output logic              done
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    rx_state_e         state_q;
    logic              prev_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDLE_W-1:0] quiet_q;
    logic              active;
    logic              edge_s;
    logic              quiet_hit;
    logic              len_full;

    // Event decode for the current cycle.
    always_comb begin
        active    = (state_q == RX_RUN) && rx_en;
        edge_s    = active && (lvl != prev_q);
        quiet_hit = (quiet_q >= idle_thr);
        len_full  = (len_q == LEN_MAX);
        wr_req    = edge_s || (active && tick && (quiet_hit || len_full));
        if (edge_s)         wr_entry = '{level: prev_q, len: len_q};
        else if (quiet_hit) wr_entry = '{level: lvl, len: '0};
        else                wr_entry = '{level: lvl, len: LEN_MAX};
        done      = (state_q == RX_STOP);
    end

    // State, previous level and the two tick counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
            prev_q  <= 1'b0;
            len_q   <= '0;
            quiet_q <= '0;
        end else begin
            prev_q <= lvl;
            case (state_q)
                RX_OFF: if (rx_en) begin
                    state_q <= RX_RUN;
                    len_q   <= '0;
                    quiet_q <= '0;
                end
                RX_RUN: if (!rx_en) begin
                    state_q <= RX_OFF;
                end else if (edge_s) begin
                    len_q   <= tick ? LEN_W'(1) : '0;
                    quiet_q <= tick ? IDLE_W'(1) : '0;
                end else if (tick) begin
                    if (quiet_hit) begin
                        state_q <= RX_STOP;
                    end else begin
                        len_q   <= len_full ? LEN_W'(1) : len_q + LEN_W'(1);
                        quiet_q <= quiet_q + IDLE_W'(1);
                    end
                end
                default: if (!rx_en) state_q <= RX_OFF;
            endcase
        end
    end

    // R5
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP) |-> !wr_req);
endmodule

// File: rtl/pwcap_entry_mem.sv
// Entry memory: stores entries at an incrementing write position, drops
// writes when full and flags that, and offers a combinational read port.
// Assumes a write-position reset takes priority over a same-cycle write.
module pwcap_entry_mem
    import pwcap_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  run_entry_t        wr_entry,
    input  logic              ptr_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [ADDR_W:0]   count,
    output logic              err
);
    localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W+1)'(DEPTH);

    run_entry_t      store_q [DEPTH];
    logic [ADDR_W:0] cnt_q;
    logic            err_q;
    logic            full;
    logic            do_wr;

    // Write qualification.
    always_comb begin
        full  = (cnt_q == FULL_CNT);
        do_wr = wr_req && !full && !ptr_clr;
    end

    // Write position and sticky full-write error.
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_clr) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (wr_req) begin
            if (full) err_q <= 1'b1;
            else      cnt_q <= cnt_q + (ADDR_W+1)'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // One entry slot, written when the position points at it.
        always_ff @(posedge clk) begin
            if (!rst_n) store_q[i] <= '0;
            else if (do_wr && cnt_q == (ADDR_W+1)'(i)) store_q[i] <= wr_entry;
        end
    end

    // Combinational read.
    always_comb begin
        if (32'(rd_addr) < DEPTH) rd_data = store_q[rd_addr];
        else                      rd_data = '0;
    end

    assign count = cnt_q;
    assign err   = err_q;

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(wr_req && full));
endmodule

// File: rtl/pwcap_rx.sv
// Pulse-width capture receiver top: divider, glitch filter, run timer and
// entry memory. Assumes sig_in is synchronous to clk or already synchronised.
module pwcap_rx
    import pwcap_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int THR_W  = 8,
    parameter int IDLE_W = 16,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sig_in,
    input  logic [DIV_W-1:0]   div_factor,
    input  logic               div_rst,
    input  logic               filt_en,
    input  logic [THR_W-1:0]   filt_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    input  logic               rx_en,
    input  logic               wptr_rst,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [ADDR_W:0]    wr_count,
    output logic               rx_done,
    output logic               rx_err
);
    logic       tick;
    logic       lvl;
    logic       wr_req;
    run_entry_t wr_entry;

    pwcap_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .factor(div_factor),
        .restart(div_rst), .tick(tick)
    );

    pwcap_glitch_filter #(.THR_W(THR_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
        .en(filt_en), .thr(filt_thr), .lvl(lvl)
    );

    pwcap_run_timer #(.IDLE_W(IDLE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(lvl),
        .rx_en(rx_en), .idle_thr(idle_thr),
        .wr_req(wr_req), .wr_entry(wr_entry), .done(rx_done)
    );

    pwcap_entry_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_entry(wr_entry),
        .ptr_clr(wptr_rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .count(wr_count), .err(rx_err)
    );

    // R6
    off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !wr_req);
endmodule

// File: tb/sim_pwcap_rx.sv
`timescale 1ns/1ps
module sim_pwcap_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic [7:0]  div_factor = 8'd1;
    logic        div_rst = 1'b0;
    logic        filt_en = 1'b0;
    logic [7:0]  filt_thr = 8'd0;
    logic [15:0] idle_thr = 16'd50;
    logic        rx_en = 1'b0;
    logic        wptr_rst = 1'b0;
    logic [3:0]  rd_addr = 4'd0;
    logic [15:0] rd_data;
    logic [4:0]  wr_count;
    logic        rx_done;
    logic        rx_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwcap_rx u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .div_factor(div_factor),
        .div_rst(div_rst), .filt_en(filt_en), .filt_thr(filt_thr),
        .idle_thr(idle_thr), .rx_en(rx_en), .wptr_rst(wptr_rst),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_count(wr_count),
        .rx_done(rx_done), .rx_err(rx_err)
    );

    // Vector: {div, filter enable, filter threshold, high length, low length} in cycles.
    localparam logic [39:0] VECS [4] = '{
        {8'd1, 8'd0, 8'd0, 8'd7,  8'd13},
        {8'd2, 8'd0, 8'd0, 8'd10, 8'd6},
        {8'd4, 8'd1, 8'd3, 8'd12, 8'd20},
        {8'd1, 8'd1, 8'd5, 8'd5,  8'd9}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int n);
        sig_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_ptr();
        wptr_rst = 1'b1;
        @(negedge clk);
        wptr_rst = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int k = 0; k < limit && !rx_done; k++) @(negedge clk);
    endtask

    function automatic int ent(input logic lv, input int len);
        return int'({lv, 15'(len)});
    endfunction

    task automatic read_at(input int a, output int d);
        rd_addr = 4'(a);
        #0.5;
        d = int'(rd_data);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(wr_count == 0, "R10 count", int'(wr_count), 0);
        chk(rx_done == 0 && rx_err == 0, "R10 flags", int'({rx_done, rx_err}), 0);
        read_at(3, d);
        chk(d == 0, "R10 entry", d, 0);

        // R1 R2 R4 R5 R11: vector table
        for (int v = 0; v < 4; v++) begin
            int dv, hl, ll;
            dv = int'(VECS[v][39:32]);
            hl = int'(VECS[v][15:8]);
            ll = int'(VECS[v][7:0]);
            rx_en = 1'b0;
            div_factor = VECS[v][39:32];
            filt_en = VECS[v][24];
            filt_thr = VECS[v][23:16];
            idle_thr = 16'd50;
            sig_in = 1'b0;
            repeat (8) @(negedge clk);
            clear_ptr();
            rx_en = 1'b1;
            drive(1'b0, 10);
            drive(1'b1, hl);
            drive(1'b0, ll);
            drive(1'b1, hl);
            sig_in = 1'b0;
            wait_done(1000);
            chk(rx_done == 1, "R5 done", int'(rx_done), 1);
            chk(wr_count == 5, "R1 count", int'(wr_count), 5);
            read_at(0, d);
            chk(d[15] == 1'b0, "R1 first level", d[15], 0);
            read_at(1, d);
            chk(d == ent(1, hl / dv), "R2 high run", d, ent(1, hl / dv));
            read_at(2, d);
            chk(d == ent(0, ll / dv), "R2 low run", d, ent(0, ll / dv));
            read_at(3, d);
            chk(d == ent(1, hl / dv), "R11 read", d, ent(1, hl / dv));
            read_at(4, d);
            chk(d == ent(0, 0), "R5 terminator", d, 0);
        end

        // R6: done drops with rx_en, no writes while disabled
        rx_en = 1'b0;
        @(negedge clk);
        chk(rx_done == 0, "R6 done cleared", int'(rx_done), 0);
        clear_ptr();
        filt_en = 1'b0; div_factor = 8'd1;
        for (int k = 0; k < 6; k++) drive(k[0] ? 1'b0 : 1'b1, 4);
        drive(1'b0, 5);
        chk(wr_count == 0, "R6 no writes", int'(wr_count), 0);

        // R4: 4-cycle pulse dropped by a threshold of 5
        filt_en = 1'b1; filt_thr = 8'd5; idle_thr = 16'd30;
        clear_ptr();
        rx_en = 1'b1;
        drive(1'b0, 10);
        drive(1'b1, 4);
        sig_in = 1'b0;
        wait_done(500);
        chk(wr_count == 1, "R4 glitch dropped", int'(wr_count), 1);
        read_at(0, d);
        chk(d == 0, "R4 only terminator", d, 0);
        rx_en = 1'b0;
        @(negedge clk);
        // R4: same pulse passes with the filter off
        filt_en = 1'b0;
        clear_ptr();
        rx_en = 1'b1;
        drive(1'b0, 10);
        drive(1'b1, 4);
        sig_in = 1'b0;
        wait_done(500);
        chk(wr_count == 3, "R4 unfiltered", int'(wr_count), 3);
        read_at(1, d);
        chk(d == ent(1, 4), "R4 pulse length", d, ent(1, 4));
        rx_en = 1'b0;
        @(negedge clk);

        // R5: timeout window, idle_thr = 10 ticks at div 1
        idle_thr = 16'd10;
        clear_ptr();
        rx_en = 1'b1;
        drive(1'b0, 4);
        drive(1'b1, 4);
        sig_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(rx_done == 0, "R5 not early", int'(rx_done), 0);
        repeat (10) @(negedge clk);
        chk(rx_done == 1, "R5 fired", int'(rx_done), 1);
        rx_en = 1'b0;
        @(negedge clk);

        // R3: divider held in restart stops the timeout
        div_factor = 8'd8; idle_thr = 16'd4;
        div_rst = 1'b1;
        clear_ptr();
        rx_en = 1'b1;
        repeat (100) @(negedge clk);
        chk(rx_done == 0, "R3 held", int'(rx_done), 0);
        div_rst = 1'b0;
        repeat (60) @(negedge clk);
        chk(rx_done == 1, "R3 released", int'(rx_done), 1);
        rx_en = 1'b0;
        @(negedge clk);

        // R8 R9: overflow
        div_factor = 8'd1; idle_thr = 16'd50;
        clear_ptr();
        rx_en = 1'b1;
        for (int k = 0; k < 22; k++) drive(k[0] ? 1'b0 : 1'b1, 3);
        sig_in = 1'b0;
        wait_done(500);
        chk(wr_count == 16, "R8 count held", int'(wr_count), 16);
        chk(rx_err == 1, "R8 error", int'(rx_err), 1);
        rx_en = 1'b0;
        @(negedge clk);
        clear_ptr();
        chk(wr_count == 0 && rx_err == 0, "R9 cleared", int'({wr_count, rx_err}), 0);

        // R7: saturated length
        idle_thr = 16'd60000;
        rx_en = 1'b1;
        drive(1'b0, 10);
        drive(1'b1, 40000);
        drive(1'b0, 10);
        chk(wr_count == 3, "R7 count", int'(wr_count), 3);
        read_at(1, d);
        chk(d == ent(1, 32767), "R7 saturated", d, ent(1, 32767));
        read_at(2, d);
        chk(d == ent(1, 7233), "R7 remainder", d, ent(1, 7233));
        rx_en = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule